// File: doc/BRIEF.md
# Cascaded Q1.31 Second-Order IIR Filter Chain

This block filters one audio channel through a chain of second-order recursive sections. It sits after the input summer and before the volume stage. A signed sample enters with a valid strobe. It passes through every section, one register stage per section, and leaves with its own valid strobe. A saturation flag travels with each output sample.

A host programs each section through a byte-wide write port. Every section holds five signed 1.31 coefficients: three feed-forward taps and two feedback taps. Each coefficient is loaded one byte at a time. The section switches to the new 32-bit value only when the last byte of that coefficient arrives. The middle feed-forward tap and the first feedback tap count twice in the sum. The feedback taps are stored with their sign already flipped, so they are added rather than subtracted.

Writes take effect only while the channel is disabled. Enabling the channel starts from clean delay lines. After reset, every section passes the signal through at 0 dB.

Top module: `biquad_chain`

## Requirements
- R1: Each section s (0..N_SECT-1) holds five 32-bit two's-complement 1.31 coefficients with index k = 0..4: the three feed-forward taps F0, F1, F2, then the two feedback taps B1, B2. Byte b (0..3) of coefficient k sits at address 20·s + 4·k + b, with b = 0 holding bits 31..24 and b = 3 holding bits 7..0.
- R2: A coefficient changes only when its byte b = 3 is written. The new value is the bytes staged earlier at b = 0..2 of that coefficient, joined with the written byte. Writes to b = 0..2 alone leave every coefficient unchanged.
- R3: After reset out_valid and out_sat are 0. Every section holds F0 = 0x7FFFFFFF and all other taps 0, so each section outputs floor(x·(2^31−1)/2^31).
- R4: For each accepted sample a section computes y = sat((F0·x[n] + 2·F1·x[n−1] + F2·x[n−2] + 2·B1·y[n−1] + B2·y[n−2]) >>> 31). The arithmetic shift floors the result. The delay lines hold the section's own past inputs and past saturated outputs.
- R5: Section s+1 takes the output of section s. A sample accepted at a clock edge appears on out_data with out_valid high N_SECT−1 edges later. Back-to-back samples give back-to-back outputs.
- R6: A write presented while chan_en is 1 changes no staged byte and no coefficient.
- R7: While chan_en is 0, in_valid is ignored, out_valid stays 0, and all delay lines and in-flight samples are cleared. The first sample after enabling sees zero history.
- R8: A shifted sum above 2^31−1 gives 0x7FFFFFFF, and one below −2^31 gives 0x80000000. When any section saturates a sample, out_sat is 1 in the cycle that sample's out_valid is 1. out_sat is never 1 without out_valid.
- R9: Writes to addresses at or above 20·N_SECT (60 by default) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; locks coefficients and clears state when low |
| wr_en | input | 1 | Coefficient byte write strobe |
| wr_addr | input | ADDR_W | Coefficient byte address |
| wr_data | input | 8 | Coefficient byte value |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Signed filtered sample |
| out_sat | output | 1 | Sample was clipped in at least one section |

## Verification
The hardest cases to reach are the ones that depend on stored history. Examples are feedback saturation in one section feeding the next, and the moment the channel is disabled while samples are still in the pipeline. The stimulus first loads full-scale doubled taps and drives full-scale samples of both signs. It then drops chan_en in the middle of a stream while in_valid stays high, and re-enables it. Partial coefficient writes, writes during operation and writes to unmapped addresses are each followed by a sample stream. That way any corruption of a coefficient shows up in out_data.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
   // number of coefficients per section and their index order
   localparam int unsigned NUM_TAP = 5;
   typedef enum logic [2:0] {
      TAP_F0 = 3'd0,
      TAP_F1 = 3'd1,
      TAP_F2 = 3'd2,
      TAP_B1 = 3'd3,
      TAP_B2 = 3'd4
   } tap_e;
endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank
   import biquad_pkg::*;
#(
   parameter int unsigned N_SECT = 3,
   parameter int unsigned COEF_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              chan_en,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [7:0]                        wr_data,
   output logic [N_SECT*NUM_TAP*COEF_W-1:0]  coef_flat
);
   localparam int unsigned BPC     = COEF_W / 8;
   localparam int unsigned N_COEF  = N_SECT * NUM_TAP;
   localparam int unsigned N_BYTES = N_COEF * BPC;
   localparam int unsigned IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
   localparam int unsigned CI_W    = (N_COEF > 1) ? $clog2(N_COEF) : 1;
   localparam logic [COEF_W-1:0] UNITY = {1'b0, {(COEF_W-1){1'b1}}};

   logic [7:0]        stage [N_BYTES];
   logic              wr_ok;
   logic              commit;
   logic [ADDR_W-1:0] pos;
   logic [ADDR_W-1:0] base;
   logic [CI_W-1:0]   cidx;
   logic [COEF_W-1:0] assembled;

   assign wr_ok  = wr_en && !chan_en && (wr_addr < ADDR_W'(N_BYTES));
   assign pos    = wr_addr % ADDR_W'(BPC);
   assign base   = wr_addr - pos;
   assign cidx   = CI_W'(wr_addr / ADDR_W'(BPC));
   assign commit = wr_ok && (pos == ADDR_W'(BPC-1));

   always_comb begin
      assembled = '0;
      for (int b = 0; b < int'(BPC) - 1; b++) begin
         assembled[COEF_W-1-8*b -: 8] = stage[IDX_W'(base + ADDR_W'(b))];
      end
      assembled[7:0] = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N_BYTES); i++) stage[i] <= '0;
      end else if (wr_ok) begin
         stage[IDX_W'(wr_addr)] <= wr_data;
      end
   end

   for (genvar i = 0; i < int'(N_COEF); i++) begin : g_coef
      localparam logic [COEF_W-1:0] RST_VAL =
         ((i % NUM_TAP) == int'(TAP_F0)) ? UNITY : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            coef_flat[i*COEF_W +: COEF_W] <= RST_VAL;
         end else if (commit && (cidx == CI_W'(i))) begin
            coef_flat[i*COEF_W +: COEF_W] <= assembled;
         end
      end
   end
endmodule

// File: rtl/biquad_section.sv
module biquad_section
   import biquad_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned COEF_W = 32,
   parameter int unsigned ACC_W  = 66
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          in_valid,
   input  logic signed [DATA_W-1:0]      in_data,
   input  logic                          in_sat,
   input  logic [NUM_TAP*COEF_W-1:0]     coefs,
   output logic                          out_valid,
   output logic signed [DATA_W-1:0]      out_data,
   output logic                          out_sat
);
   localparam int unsigned MW   = DATA_W + COEF_W;
   localparam int unsigned FRAC = COEF_W - 1;
   localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [COEF_W-1:0] f0, f1, f2, b1, b2;
   logic signed [DATA_W-1:0] x1, x2, y1, y2, y_now;
   logic signed [MW-1:0]     m0, m1, m2, m3, m4;
   logic signed [ACC_W-1:0]  acc, shr;
   logic [ACC_W-DATA_W:0]    hi;
   logic                     ovf;

   assign f0 = coefs[int'(TAP_F0)*COEF_W +: COEF_W];
   assign f1 = coefs[int'(TAP_F1)*COEF_W +: COEF_W];
   assign f2 = coefs[int'(TAP_F2)*COEF_W +: COEF_W];
   assign b1 = coefs[int'(TAP_B1)*COEF_W +: COEF_W];
   assign b2 = coefs[int'(TAP_B2)*COEF_W +: COEF_W];

   assign m0 = MW'(in_data) * MW'(f0);
   assign m1 = MW'(x1)      * MW'(f1);
   assign m2 = MW'(x2)      * MW'(f2);
   assign m3 = MW'(y1)      * MW'(b1);
   assign m4 = MW'(y2)      * MW'(b2);

   // doubled taps F1 and B1, feedback added
   assign acc = ACC_W'(m0) + (ACC_W'(m1) <<< 1) + ACC_W'(m2)
              + (ACC_W'(m3) <<< 1) + ACC_W'(m4);
   assign shr = acc >>> FRAC;
   assign hi  = shr[ACC_W-1:DATA_W-1];
   assign ovf = !((&hi) || !(|hi));
   assign y_now = ovf ? (shr[ACC_W-1] ? NEG_MAX : POS_MAX) : shr[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
         out_valid <= 1'b0; out_data <= '0; out_sat <= 1'b0;
      end else if (clr) begin
         x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
         out_valid <= 1'b0; out_sat <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            x1 <= in_data; x2 <= x1;
            y1 <= y_now;   y2 <= y1;
            out_data <= y_now;
            out_sat  <= in_sat | ovf;
         end else begin
            out_sat <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/biquad_chain.sv
module biquad_chain
   import biquad_pkg::*;
#(
   parameter int unsigned N_SECT = 3,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned COEF_W = 32,
   parameter int unsigned ACC_W  = 66,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     chan_en,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data,
   output logic                     out_sat
);
   localparam int unsigned SEC_BITS = NUM_TAP * COEF_W;
   localparam int unsigned N_BYTES  = N_SECT * NUM_TAP * (COEF_W / 8);

   if (N_SECT < 1) begin : g_bad_sect
      $error("N_SECT must be at least 1");
   end
   if ((COEF_W % 8) != 0 || COEF_W < 16) begin : g_bad_coef
      $error("COEF_W must be a multiple of 8 and at least 16");
   end
   if (ACC_W < DATA_W + COEF_W + 2) begin : g_bad_acc
      $error("ACC_W too narrow for the five-term sum");
   end
   if (N_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the coefficient space");
   end

   logic [N_SECT*SEC_BITS-1:0] coef_flat;
   logic                       sv [N_SECT+1];
   logic                       ss [N_SECT+1];
   logic signed [DATA_W-1:0]   sd [N_SECT+1];

   biquad_coef_bank #(
      .N_SECT(N_SECT), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .coef_flat(coef_flat)
   );

   assign sv[0] = in_valid & chan_en;
   assign sd[0] = in_data;
   assign ss[0] = 1'b0;

   for (genvar s = 0; s < int'(N_SECT); s++) begin : g_sect
      biquad_section #(
         .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
      ) u_sec (
         .clk(clk), .rst_n(rst_n), .clr(!chan_en),
         .in_valid(sv[s]), .in_data(sd[s]), .in_sat(ss[s]),
         .coefs(coef_flat[s*SEC_BITS +: SEC_BITS]),
         .out_valid(sv[s+1]), .out_data(sd[s+1]), .out_sat(ss[s+1])
      );
   end

   assign out_valid = sv[N_SECT];
   assign out_data  = sd[N_SECT];
   assign out_sat   = ss[N_SECT];
endmodule

// File: rtl/biquad_chain_chk.sv
module biquad_chain_chk #(
   parameter int unsigned N_SECT = 3,
   parameter int unsigned COEF_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           chan_en,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              wr_addr,
   input logic                           in_valid,
   input logic                           out_valid,
   input logic                           out_sat,
   input logic [N_SECT*5*COEF_W-1:0]     coef_flat
);
   localparam int unsigned N_BYTES = N_SECT * 5 * (COEF_W / 8);
   localparam int unsigned BPC     = COEF_W / 8;

   logic [N_SECT-1:0] pipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pipe <= '0;
      else if (!chan_en) pipe <= '0;
      else               pipe <= (pipe << 1) | N_SECT'(in_valid);
   end

   // R5
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == pipe[N_SECT-1]);

   // R6
   lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && chan_en) |=> $stable(coef_flat));

   // R7
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !out_valid);

   // R8
   satv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sat |-> out_valid);

   // R9
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr >= ADDR_W'(N_BYTES))) |=> $stable(coef_flat));

   // R2
   partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((wr_addr % ADDR_W'(BPC)) != ADDR_W'(BPC-1))) |=> $stable(coef_flat));
endmodule

bind biquad_chain biquad_chain_chk #(
   .N_SECT(N_SECT), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .in_valid(in_valid), .out_valid(out_valid),
   .out_sat(out_sat), .coef_flat(coef_flat)
);

// File: tb/sim_biquad_chain.sv
`timescale 1ns/1ps
module sim_biquad_chain;
   localparam int NS = 3;

   logic clk = 1'b0;
   logic rst_n, chan_en, wr_en, in_valid;
   logic [7:0] wr_addr, wr_data;
   logic signed [31:0] in_data;
   logic out_valid, out_sat;
   logic signed [31:0] out_data;

   always #2.5 clk = ~clk;

   biquad_chain u0 (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .out_sat(out_sat)
   );

   int total = 0;
   int bad = 0;
   string cur_req = "R3";

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct { int due; logic signed [31:0] d; bit s; } exp_t;
   exp_t q[$];
   int cyc = 0;
   logic signed [31:0] cf [NS][5];
   logic [7:0] stg [NS*20];
   logic signed [31:0] mx1 [NS], mx2 [NS], my1 [NS], my2 [NS];

   function automatic logic signed [31:0] sect(int s, logic signed [31:0] x, inout bit sat);
      logic signed [71:0] acc, sh;
      logic signed [31:0] y;
      acc = 72'(cf[s][0]) * 72'(x)
          + ((72'(cf[s][1]) * 72'(mx1[s])) <<< 1)
          + 72'(cf[s][2]) * 72'(mx2[s])
          + ((72'(cf[s][3]) * 72'(my1[s])) <<< 1)
          + 72'(cf[s][4]) * 72'(my2[s]);
      sh = acc >>> 31;
      if (sh > 72'sd2147483647) begin y = 32'h7FFFFFFF; sat = 1; end
      else if (sh < -72'sd2147483648) begin y = 32'h80000000; sat = 1; end
      else y = sh[31:0];
      mx2[s] = mx1[s]; mx1[s] = x; my2[s] = my1[s]; my1[s] = y;
      return y;
   endfunction

   task automatic model_clear();
      for (int s = 0; s < NS; s++) begin
         mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
      end
      q.delete();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         model_clear();
         for (int s = 0; s < NS; s++)
            for (int k = 0; k < 5; k++) cf[s][k] = (k == 0) ? 32'h7FFFFFFF : 32'h0;
         for (int a = 0; a < NS*20; a++) stg[a] = 8'h00;
      end else begin
         if (!chan_en) model_clear();
         else if (in_valid) begin
            logic signed [31:0] v;
            bit sat;
            exp_t e;
            v = in_data; sat = 0;
            for (int s = 0; s < NS; s++) v = sect(s, v, sat);
            e.due = cyc + NS - 1; e.d = v; e.s = sat;
            q.push_back(e);
         end
         if (wr_en && !chan_en && wr_addr < NS*20) begin
            stg[wr_addr] = wr_data;
            if (wr_addr % 4 == 3) begin
               int b0;
               b0 = wr_addr - 3;
               cf[b0/20][(b0%20)/4] = {stg[b0], stg[b0+1], stg[b0+2], wr_data};
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            check(out_valid === 1'b1, cur_req, 64'(out_valid), 64'd1);
            check(out_data === q[0].d, cur_req, 64'(out_data), 64'(q[0].d));
            check(out_sat === q[0].s, cur_req, 64'(out_sat), 64'(q[0].s));
            void'(q.pop_front());
         end else begin
            check(out_valid === 1'b0, cur_req, 64'(out_valid), 64'd0);
            check(out_sat === 1'b0, cur_req, 64'(out_sat), 64'd0);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr_byte(int a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_coef(int s, int k, logic [31:0] v);
      for (int b = 0; b < 4; b++) wr_byte(s*20 + k*4 + b, v[31-8*b -: 8]);
   endtask

   task automatic send(int n, int gap, int mode);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = (($urandom % 100) >= gap);
         case (mode)
            1: in_data = 32'h7FFFFFFF;
            2: in_data = 32'h80000000;
            3: in_data = (i % 2) ? 32'h80000000 : 32'h7FFFFFFF;
            default: in_data = $signed($urandom) >>> 3;
         endcase
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (NS + 4) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; chan_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      in_valid = 1'b0; in_data = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      check(out_valid === 1'b0, "R3", 64'(out_valid), 64'd0);
      check(out_sat === 1'b0, "R3", 64'(out_sat), 64'd0);

      // R3 default all-pass response
      cur_req = "R3";
      chan_en = 1'b1;
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'sd1000;
      @(negedge clk);
      in_valid = 1'b0;
      send(20, 30, 0);
      drain();

      // R1 programming of all three sections
      cur_req = "R1";
      chan_en = 1'b0;
      wr_coef(0, 0, 32'h20000000); wr_coef(0, 1, 32'h20000000);
      wr_coef(0, 2, 32'h20000000); wr_coef(0, 3, 32'h30000000);
      wr_coef(0, 4, 32'hE0000000);
      wr_coef(1, 0, 32'h40000000); wr_coef(1, 1, 32'hC0000000);
      wr_coef(1, 2, 32'h40000000); wr_coef(1, 3, 32'h20000000);
      wr_coef(1, 4, 32'hF0000000);
      wr_coef(2, 0, 32'h60000000); wr_coef(2, 3, 32'h10000000);

      // R4 difference equation with gaps
      cur_req = "R4";
      chan_en = 1'b1;
      send(60, 40, 0);
      drain();

      // R5 back-to-back throughput
      cur_req = "R5";
      send(30, 0, 0);
      drain();

      // R2 partial write leaves coefficient alone
      cur_req = "R2";
      chan_en = 1'b0;
      wr_byte(40, 8'hFF); wr_byte(41, 8'hFF); wr_byte(42, 8'hFF);
      chan_en = 1'b1;
      send(20, 20, 0);
      drain();
      chan_en = 1'b0;
      wr_byte(43, 8'h00);       // commits staged bytes
      chan_en = 1'b1;
      send(20, 20, 0);
      drain();

      // R6 writes during operation ignored
      cur_req = "R6";
      for (int a = 0; a < 20; a++) wr_byte(a, 8'h5A);
      send(25, 20, 0);
      drain();

      // R9 out-of-range addresses ignored
      cur_req = "R9";
      chan_en = 1'b0;
      for (int a = 60; a < 72; a++) wr_byte(a, 8'hA5);
      wr_byte(255, 8'h81);
      chan_en = 1'b1;
      send(25, 20, 0);
      drain();

      // R8 saturation both signs
      cur_req = "R8";
      chan_en = 1'b0;
      wr_coef(0, 0, 32'h7FFFFFFF); wr_coef(0, 1, 32'h7FFFFFFF);
      wr_coef(0, 2, 32'h7FFFFFFF); wr_coef(0, 3, 32'h00000000);
      wr_coef(0, 4, 32'h00000000);
      chan_en = 1'b1;
      send(8, 0, 1);
      send(8, 0, 2);
      send(10, 0, 3);
      drain();

      // R7 disable mid-stream clears state and in-flight samples
      cur_req = "R7";
      chan_en = 1'b0;
      wr_coef(1, 3, 32'h38000000);
      chan_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = 32'sd4000000 * (i + 1);
      end
      chan_en = 1'b0;         // in_valid still high
      repeat (5) @(negedge clk);
      chan_en = 1'b1;
      repeat (6) @(negedge clk);
      in_valid = 1'b0;
      send(20, 25, 0);
      drain();

      check(q.size() == 0, "R5", 64'(q.size()), 64'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule